// File: doc/BRIEF.md
# In-Order Retirement Reorder Buffer

This block keeps the program order of instructions that an out-of-order core has sent to its execution units, and retires them strictly in that order. A dispatch stage asks for up to four slots per clock and gets back a tag for each one. Execution units later report completion by tag, together with two flags: the instruction raised an exception, or it is a branch whose prediction was wrong. The retire port lists, oldest first, the consecutive run of finished entries at the head of the buffer. At most four appear per clock.

A wrong branch prediction discards every entry younger than the branch in the same clock as the report. The branch itself stays and retires later. An exception is handled precisely. Retirement stops at the faulting entry. Once every older entry has left, the block discards that entry and everything behind it, so that the core can restart at that instruction. Renaming, operand data and exception vectoring are left to neighbouring blocks.

Top module: `reorder_retire_buf`

## Requirements
- R1: After reset the buffer is empty: `ret_cnt` is 0, `flush_valid` is 0, `disp_ok` is 1 for a zero request and the first offered tag (slot 0 of `disp_tags`) is 0.
- R2: A dispatch request of `disp_cnt` entries (0 to 4) that fits is granted in the same cycle. Slot k of `disp_tags` (bits 4k+3:4k) holds tag (tail + k) mod 16, and the granted entries are allocated at the clock edge.
- R3: A request for more than four entries, or for more entries than are free, is refused with `disp_ok` 0 and allocates nothing. The next granted request is offered the same tags.
- R4: An entry retires only after it has finished and every older entry has retired. `ret_cnt` is driven from registered state, so a finish reported before an edge can retire in the cycle after that edge at the earliest. Slot k of `ret_tags` (bits 4k+3:4k) is the k-th oldest retiring tag.
- R5: No more than four entries retire in one cycle. A longer run of finished entries drains over the following cycles.
- R6: The buffer holds 16 entries. Sixteen in-flight entries are accepted and a 17th request is refused.
- R7: A finish with `fin_mispred` on a live tag T raises `flush_valid` in the same cycle, with `flush_exc` 0 and `flush_tag` = T+1 mod 16. Every entry younger than T is discarded, and the next dispatch is offered tag T+1 mod 16.
- R8: Entries that retire in the cycle of a mispredict report still retire. The discard then applies only to entries younger than the branch.
- R9: An entry finished with `fin_exc` blocks retirement at itself. When it becomes the oldest entry, `flush_valid` and `flush_exc` are 1, `flush_tag` is its tag and `ret_cnt` is 0. All entries are discarded, and the next dispatch is offered that same tag.
- R10: A finish report for a tag that is not in flight (never allocated, or already discarded) has no effect. A later allocation of that tag does not count as finished.
- R11: While `flush_valid` is 1, dispatch is refused (`disp_ok` is 0).
- R12: Tags wrap modulo 16. A dispatch group crossing tag 15 continues at tag 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| disp_cnt | input | 3 | Number of entries requested this cycle (0 to 4) |
| disp_ok | output | 1 | Request granted this cycle |
| disp_tags | output | 16 | Four 4-bit tags offered to the request, slot 0 in the low bits |
| fin_valid | input | 1 | Finish report present |
| fin_tag | input | 4 | Tag of the finished entry |
| fin_exc | input | 1 | Finished entry raised an exception |
| fin_mispred | input | 1 | Finished entry is a mispredicted branch |
| ret_cnt | output | 3 | Number of entries retiring this cycle |
| ret_tags | output | 16 | Retiring tags, oldest in slot 0 |
| flush_valid | output | 1 | Entries are being discarded this cycle |
| flush_exc | output | 1 | Discard is caused by an exception (0: mispredict) |
| flush_tag | output | 4 | Oldest discarded tag, where the core restarts |

## Verification
The hardest case to reach is a retirement and a mispredict discard in the same clock, with the pointer arithmetic wrapped past tag 15. The stimulus fills all sixteen entries with a group that crosses the wrap point. It then finishes the oldest entry, and in the very next cycle, while that entry is on the retire port, reports a mispredict on a branch two entries further on. Finish reports for the discarded tags are then sent before those tags are handed out again. This exposes any stale finished state through the retire count of the reallocated entries.

// File: rtl/rob_pkg.sv
package rob_pkg;

  typedef enum logic [1:0] {
    FL_NONE    = 2'd0,
    FL_MISPRED = 2'd1,
    FL_EXCEPT  = 2'd2
  } flush_kind_e;

  // distance of a tag from a base pointer around a ring of the given depth
  function automatic int unsigned ring_age(int unsigned tag, int unsigned base,
                                           int unsigned depth);
    return (tag + depth - base) % depth;
  endfunction

  // pointer advanced by a step around the ring
  function automatic int unsigned ring_add(int unsigned ptr, int unsigned step,
                                           int unsigned depth);
    return (ptr + step) % depth;
  endfunction

endpackage

// File: rtl/rob_entry_array.sv
module rob_entry_array #(
  parameter int DEPTH = 16,
  parameter int TAG_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DEPTH-1:0] alloc_mask,
  input  logic [DEPTH-1:0] retire_mask,
  input  logic [DEPTH-1:0] kill_mask,
  input  logic             fin_set,
  input  logic [TAG_W-1:0] fin_tag,
  input  logic             fin_exc,
  output logic [DEPTH-1:0] valid_o,
  output logic [DEPTH-1:0] done_o,
  output logic [DEPTH-1:0] exc_o
);

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    logic fin_hit;
    assign fin_hit = fin_set && (32'(fin_tag) == i);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        valid_o[i] <= 1'b0;
        done_o[i]  <= 1'b0;
        exc_o[i]   <= 1'b0;
      end else if (kill_mask[i] || retire_mask[i]) begin
        valid_o[i] <= 1'b0;
        done_o[i]  <= 1'b0;
        exc_o[i]   <= 1'b0;
      end else if (alloc_mask[i]) begin
        valid_o[i] <= 1'b1;
        done_o[i]  <= 1'b0;
        exc_o[i]   <= 1'b0;
      end else if (fin_hit && valid_o[i]) begin
        done_o[i]  <= 1'b1;
        exc_o[i]   <= fin_exc;
      end
    end

    AST_ALLOC_FREE: assert property (@(posedge clk) disable iff (!rst_n)
      alloc_mask[i] |-> !valid_o[i]); // R6
    AST_RETIRE_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
      retire_mask[i] |-> (valid_o[i] && done_o[i])); // R4
  end

endmodule

// File: rtl/rob_dispatch.sv
module rob_dispatch #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 4,
  parameter int TAG_W = 4,
  parameter int CNT_W = 5,
  parameter int REQ_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [TAG_W-1:0]   tail,
  input  logic [CNT_W-1:0]   occ,
  input  logic [REQ_W-1:0]   req_cnt,
  input  logic               block,
  output logic               grant,
  output logic [WIDTH*TAG_W-1:0] tags,
  output logic [DEPTH-1:0]   alloc_mask,
  output logic [REQ_W-1:0]   alloc_n
);
  import rob_pkg::*;

  logic [CNT_W-1:0] free_n;
  assign free_n = CNT_W'(DEPTH) - occ;
  assign grant  = !block && (32'(req_cnt) <= WIDTH) && (CNT_W'(req_cnt) <= free_n);
  assign alloc_n = grant ? req_cnt : '0;

  for (genvar k = 0; k < WIDTH; k++) begin : g_tag
    assign tags[k*TAG_W +: TAG_W] = TAG_W'(ring_add(32'(tail), k, DEPTH));
  end

  always_comb begin
    alloc_mask = '0;
    for (int k = 0; k < WIDTH; k++) begin
      if (grant && (k < 32'(req_cnt)))
        alloc_mask[ring_add(32'(tail), k, DEPTH)] = 1'b1;
    end
  end

  AST_GRANT_FITS: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && (alloc_n != '0)) |-> (32'(occ) + 32'(alloc_n) <= DEPTH)); // R3

endmodule

// File: rtl/rob_retire_sel.sv
module rob_retire_sel #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 4,
  parameter int TAG_W = 4,
  parameter int REQ_W = 3
) (
  input  logic [TAG_W-1:0]       head,
  input  logic [DEPTH-1:0]       valid,
  input  logic [DEPTH-1:0]       done,
  input  logic [DEPTH-1:0]       exc,
  output logic [REQ_W-1:0]       ret_n,
  output logic [WIDTH*TAG_W-1:0] ret_tags,
  output logic [DEPTH-1:0]       retire_mask,
  output logic                   exc_at_head
);
  import rob_pkg::*;

  assign exc_at_head = valid[head] && done[head] && exc[head];

  always_comb begin
    logic go;
    int   n;
    go = 1'b1;
    n  = 0;
    retire_mask = '0;
    ret_tags    = '0;
    for (int k = 0; k < WIDTH; k++) begin
      int unsigned idx;
      idx = ring_add(32'(head), k, DEPTH);
      ret_tags[k*TAG_W +: TAG_W] = TAG_W'(idx);
      if (go && valid[idx] && done[idx] && !exc[idx]) begin
        retire_mask[idx] = 1'b1;
        n = n + 1;
      end else begin
        go = 1'b0;
      end
    end
    ret_n = REQ_W'(n);
  end

endmodule

// File: rtl/reorder_retire_buf.sv
module reorder_retire_buf #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 4,
  localparam int TAG_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int REQ_W = $clog2(WIDTH + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [REQ_W-1:0]       disp_cnt,
  output logic                   disp_ok,
  output logic [WIDTH*TAG_W-1:0] disp_tags,
  input  logic                   fin_valid,
  input  logic [TAG_W-1:0]       fin_tag,
  input  logic                   fin_exc,
  input  logic                   fin_mispred,
  output logic [REQ_W-1:0]       ret_cnt,
  output logic [WIDTH*TAG_W-1:0] ret_tags,
  output logic                   flush_valid,
  output logic                   flush_exc,
  output logic [TAG_W-1:0]       flush_tag
);
  import rob_pkg::*;

  logic [TAG_W-1:0] head_q, tail_q;
  logic [CNT_W-1:0] occ_q;

  logic [DEPTH-1:0] valid_v, done_v, exc_v;
  logic [DEPTH-1:0] alloc_mask, retire_mask, kill_mask;
  logic [REQ_W-1:0] alloc_n, ret_n;
  logic             exc_at_head;

  // named events for assertions
  logic        fin_hit, exc_flush, mis_flush;
  flush_kind_e fkind;
  int unsigned br_age;

  assign fin_hit   = fin_valid && valid_v[fin_tag];
  assign exc_flush = exc_at_head;
  assign mis_flush = fin_hit && fin_mispred && !exc_flush;
  assign br_age    = ring_age(32'(fin_tag), 32'(head_q), DEPTH);

  always_comb begin
    if (exc_flush)      fkind = FL_EXCEPT;
    else if (mis_flush) fkind = FL_MISPRED;
    else                fkind = FL_NONE;
  end

  assign flush_valid = (fkind != FL_NONE);
  assign flush_exc   = (fkind == FL_EXCEPT);
  assign flush_tag   = (fkind == FL_EXCEPT) ? head_q
                     : TAG_W'(ring_add(32'(fin_tag), 1, DEPTH));

  always_comb begin
    kill_mask = '0;
    if (exc_flush) begin
      kill_mask = '1;
    end else if (mis_flush) begin
      for (int i = 0; i < DEPTH; i++)
        if (ring_age(i, 32'(head_q), DEPTH) > br_age) kill_mask[i] = 1'b1;
    end
  end

  rob_dispatch #(.DEPTH(DEPTH), .WIDTH(WIDTH), .TAG_W(TAG_W), .CNT_W(CNT_W),
                 .REQ_W(REQ_W)) u_disp (
    .clk       (clk),
    .rst_n     (rst_n),
    .tail      (tail_q),
    .occ       (occ_q),
    .req_cnt   (disp_cnt),
    .block     (flush_valid),
    .grant     (disp_ok),
    .tags      (disp_tags),
    .alloc_mask(alloc_mask),
    .alloc_n   (alloc_n)
  );

  rob_retire_sel #(.DEPTH(DEPTH), .WIDTH(WIDTH), .TAG_W(TAG_W),
                   .REQ_W(REQ_W)) u_sel (
    .head       (head_q),
    .valid      (valid_v),
    .done       (done_v),
    .exc        (exc_v),
    .ret_n      (ret_n),
    .ret_tags   (ret_tags),
    .retire_mask(retire_mask),
    .exc_at_head(exc_at_head)
  );

  rob_entry_array #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u_arr (
    .clk        (clk),
    .rst_n      (rst_n),
    .alloc_mask (alloc_mask),
    .retire_mask(retire_mask),
    .kill_mask  (kill_mask),
    .fin_set    (fin_hit),
    .fin_tag    (fin_tag),
    .fin_exc    (fin_exc),
    .valid_o    (valid_v),
    .done_o     (done_v),
    .exc_o      (exc_v)
  );

  assign ret_cnt = ret_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      occ_q  <= '0;
    end else if (exc_flush) begin
      tail_q <= head_q;
      occ_q  <= '0;
    end else if (mis_flush) begin
      head_q <= TAG_W'(ring_add(32'(head_q), 32'(ret_n), DEPTH));
      tail_q <= TAG_W'(ring_add(32'(fin_tag), 1, DEPTH));
      occ_q  <= CNT_W'(br_age + 1 - 32'(ret_n));
    end else begin
      head_q <= TAG_W'(ring_add(32'(head_q), 32'(ret_n), DEPTH));
      tail_q <= TAG_W'(ring_add(32'(tail_q), 32'(alloc_n), DEPTH));
      occ_q  <= occ_q - CNT_W'(ret_n) + CNT_W'(alloc_n);
    end
  end

  AST_PTR_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    tail_q == TAG_W'(ring_add(32'(head_q), 32'(occ_q), DEPTH))); // R12
  AST_OCC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    32'(occ_q) <= DEPTH); // R6
  AST_RET_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    32'(ret_cnt) <= WIDTH); // R5
  AST_RET_FROM_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_cnt != '0) |-> (ret_tags[TAG_W-1:0] == head_q)); // R4
  AST_EXC_NO_RET: assert property (@(posedge clk) disable iff (!rst_n)
    flush_exc |-> (ret_cnt == '0)); // R9
  AST_EXC_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    exc_flush |=> (occ_q == '0)); // R9
  AST_MIS_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
    mis_flush |=> (tail_q == $past(flush_tag))); // R7
  AST_FLUSH_NO_DISP: assert property (@(posedge clk) disable iff (!rst_n)
    flush_valid |-> !disp_ok); // R11

endmodule

// File: tb/reorder_retire_buf_tb_top.sv
`timescale 1ns/1ps
module reorder_retire_buf_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  disp_cnt = '0;
  logic        disp_ok;
  logic [15:0] disp_tags;
  logic        fin_valid = 1'b0;
  logic [3:0]  fin_tag = '0;
  logic        fin_exc = 1'b0;
  logic        fin_mispred = 1'b0;
  logic [2:0]  ret_cnt;
  logic [15:0] ret_tags;
  logic        flush_valid, flush_exc;
  logic [3:0]  flush_tag;

  int checks = 0;
  int errors = 0;
  bit ended = 1'b0;
  int exp_q[$];

  always #4 clk = ~clk;

  reorder_retire_buf dut_i (
    .clk(clk), .rst_n(rst_n),
    .disp_cnt(disp_cnt), .disp_ok(disp_ok), .disp_tags(disp_tags),
    .fin_valid(fin_valid), .fin_tag(fin_tag), .fin_exc(fin_exc),
    .fin_mispred(fin_mispred),
    .ret_cnt(ret_cnt), .ret_tags(ret_tags),
    .flush_valid(flush_valid), .flush_exc(flush_exc), .flush_tag(flush_tag)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // scoreboard monitor: every retired tag must match the next expected one
  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      for (int k = 0; k < int'(ret_cnt); k++) begin
        int got;
        got = int'(ret_tags[k*4 +: 4]);
        if (exp_q.size() == 0) chk("R4 unexpected retire", got, -1);
        else chk("R4 retire order", got, exp_q.pop_front());
      end
    end
  end

  task automatic push_range(int first, int n);
    for (int k = 0; k < n; k++) exp_q.push_back((first + k) % 16);
  endtask

  task automatic do_disp(int n, bit exp_ok, int first, string req);
    disp_cnt = 3'(n);
    #1;
    chk(req, int'(disp_ok), int'(exp_ok));
    if (exp_ok)
      for (int k = 0; k < n; k++)
        chk(req, int'(disp_tags[k*4 +: 4]), (first + k) % 16);
    @(negedge clk);
    disp_cnt = '0;
  endtask

  task automatic do_fin(int tag, bit exc, bit mis);
    fin_valid = 1'b1; fin_tag = 4'(tag); fin_exc = exc; fin_mispred = mis;
    if (mis) disp_cnt = 3'd1;
    #1;
    if (mis) begin
      chk("R7 flush_valid", int'(flush_valid), 1);
      chk("R7 flush_exc", int'(flush_exc), 0);
      chk("R7 flush_tag", int'(flush_tag), (tag + 1) % 16);
      chk("R11 dispatch refused in flush", int'(disp_ok), 0);
    end
    @(negedge clk);
    fin_valid = 1'b0; fin_exc = 1'b0; fin_mispred = 1'b0; disp_cnt = '0;
  endtask

  initial begin
    #1600000;
    if (!ended) begin
      ended = 1'b1;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 ret_cnt", int'(ret_cnt), 0);
    chk("R1 flush_valid", int'(flush_valid), 0);
    chk("R1 first tag", int'(disp_tags[3:0]), 0);
    chk("R1 disp_ok", int'(disp_ok), 1);

    // R2 grouped dispatch, R4 out-of-order finish
    do_disp(4, 1'b1, 0, "R2");
    do_disp(3, 1'b1, 4, "R2");
    push_range(0, 7);
    do_fin(3, 0, 0); #1 chk("R4 wait for older", int'(ret_cnt), 0);
    do_fin(2, 0, 0);
    do_fin(1, 0, 0); #1 chk("R4 wait for older", int'(ret_cnt), 0);
    do_fin(0, 0, 0); #1 chk("R4 run of four", int'(ret_cnt), 4);
    do_fin(5, 0, 0); #1 chk("R4 gap at 4", int'(ret_cnt), 0);
    do_fin(6, 0, 0);
    do_fin(4, 0, 0); #1 chk("R4 run of three", int'(ret_cnt), 3);
    @(negedge clk);

    // R5 more than four finished
    do_disp(4, 1'b1, 7, "R2");
    do_disp(2, 1'b1, 11, "R2");
    push_range(7, 6);
    for (int t = 8; t <= 12; t++) do_fin(t, 0, 0);
    do_fin(7, 0, 0); #1 chk("R5 capped at four", int'(ret_cnt), 4);
    @(negedge clk); #1 chk("R5 remainder", int'(ret_cnt), 2);
    @(negedge clk);

    // R3 oversize request, R12 wrap, R6 full
    do_disp(5, 1'b0, 13, "R3 oversize refused");
    do_disp(4, 1'b1, 13, "R12 wrap group");
    do_disp(4, 1'b1, 1, "R6");
    do_disp(4, 1'b1, 5, "R6");
    do_disp(4, 1'b1, 9, "R6 sixteen held");
    do_disp(1, 1'b0, 0, "R6 full refused");

    // R8 retire in the mispredict cycle, R7 discard
    do_fin(13, 0, 0);
    #1 chk("R8 retire during flush", int'(ret_cnt), 1);
    chk("R8 retiring tag", int'(ret_tags[3:0]), 13);
    push_range(13, 3);
    do_fin(15, 0, 1);
    do_fin(2, 0, 0);                       // R10 discarded tag
    do_disp(1, 1'b1, 0, "R7 restart tag");
    do_disp(2, 1'b1, 1, "R7");
    push_range(0, 3);
    do_fin(14, 0, 0); #1 chk("R7 branch retires", int'(ret_cnt), 2);
    do_fin(1, 0, 0);
    do_fin(0, 0, 0); #1 chk("R10 stale finish ignored", int'(ret_cnt), 2);
    do_fin(2, 0, 0); #1 chk("R10 real finish", int'(ret_cnt), 1);
    @(negedge clk);

    // R9 precise exception
    do_disp(3, 1'b1, 3, "R2");
    exp_q.push_back(3);
    do_fin(5, 0, 0);
    do_fin(4, 1, 0);
    do_fin(3, 0, 0);
    #1 chk("R9 older retires", int'(ret_cnt), 1);
    chk("R9 no flush yet", int'(flush_valid), 0);
    @(negedge clk);
    disp_cnt = 3'd1;
    #1;
    chk("R9 flush_valid", int'(flush_valid), 1);
    chk("R9 flush_exc", int'(flush_exc), 1);
    chk("R9 flush_tag", int'(flush_tag), 4);
    chk("R9 no retire", int'(ret_cnt), 0);
    chk("R11 dispatch refused in flush", int'(disp_ok), 0);
    @(negedge clk);
    disp_cnt = '0;
    do_disp(1, 1'b1, 4, "R9 restart tag");
    exp_q.push_back(4);
    do_fin(4, 0, 0); #1 chk("R9 reissued retires", int'(ret_cnt), 1);
    repeat (2) @(negedge clk);
    chk("R4 scoreboard drained", exp_q.size(), 0);

    if (!ended) begin
      ended = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule